// File: doc/BRIEF.md
# Transfer Launch Register with Packet Buffer

This block sits between a host register bus and a byte-wide card-side stream. The host writes a launch word that holds a 4-bit transfer code, a 10-bit byte length and a buffer-select bit. A 512-byte circular packet buffer carries the payload. The host reaches the buffer one 32-bit big-endian word at a time through a data window. The card side moves one byte per handshake.

A direction bit sets the flow. In write direction the host fills the buffer and the card-side stream drains it. In read direction the card-side stream fills the buffer and the host drains it.

The block counts every byte that enters the buffer after the last launch. When the card side marks the end of a transfer, the block compares that count with the programmed length. Three flags report problems:
- an empty flag, which follows the buffer state;
- a sticky underrun flag, set when software reads an empty buffer;
- a sticky length-mismatch flag.

Register word addresses on `reg_addr`:
- 0: launch word
- 1: data window
- 2: status (write 1 to clear the sticky flags)
- 3: control (bit 0 = direction: 1 write, 0 read)

Top module: `xfer_launch_buf`

## Requirements
- R1: A write to address 0 latches the transfer code from bits 31:28, the buffer select from bit 26 and the length from bits 25:16. Address 0 reads back only these fields, in the same positions, with all other bits zero. A launch clears the byte count and leaves the buffer contents and both sticky flags unchanged.
- R2: The data window is big-endian. Bits 31:24 of a window word are the earliest byte in stream order, and bits 7:0 are the latest.
- R3: In write direction, a window write stores four bytes and adds 4 to the byte count. In read direction a window write is ignored. In write direction a window read returns zero and has no effect.
- R4: The buffer holds 512 bytes. A window write when fewer than four bytes are free is dropped whole and leaves the byte count unchanged.
- R5: In write direction with select = 1, `card_tx_valid` is high whenever the buffer holds data, and `card_tx_data` shows the oldest byte. That byte is removed on each cycle where `card_tx_ready` is high.
- R6: In read direction with select = 1, each cycle with `card_rx_valid` high stores `card_rx_data` and adds 1 to the byte count. When the buffer is full, the byte is dropped and the count is unchanged.
- R7: With select = 0, the card side is idle: `card_tx_valid` stays low and incoming card bytes are dropped.
- R8: In read direction, a window read of a non-empty buffer removes up to four bytes. Any byte position that had no data reads as zero.
- R9: Status bit 0 (empty) is high exactly when the buffer holds no bytes. Status also shows the direction in bit 3, the fill level in bits 13:4 and the byte count in bits 25:16.
- R10: A window read in read direction while the buffer is empty returns zero and sets the sticky underrun flag (status bit 1). Writing 1 to status bit 1 clears it.
- R11: On `card_end`, the byte count is compared with the programmed length. The count includes a byte accepted in the same cycle. If they differ, the sticky mismatch flag (status bit 2) is set. Writing 1 to status bit 2 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; has an effect only on the data window |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from address and state |
| card_tx_valid | output | 1 | A byte is offered to the card side |
| card_tx_data | output | 8 | Oldest buffered byte |
| card_tx_ready | input | 1 | Card side takes the offered byte |
| card_rx_valid | input | 1 | Card side delivers a byte |
| card_rx_data | input | 8 | Byte from the card side |
| card_end | input | 1 | Card side marks the end of the transfer |

## Verification
The embedded assertions check these properties on every cycle:
- the fill level never exceeds the capacity;
- an empty read always raises the underrun flag;
- the underrun flag holds until it is cleared;
- an end marker with a wrong count always raises the mismatch flag;
- a dropped host word or a dropped card byte never moves the byte count.

Only the directed scenarios can show the following:
- byte order through the window;
- data integrity across a full 512-byte wrap;
- zero padding of a short read;
- the same-cycle end-marker count;
- preservation of the flags across a relaunch;
- silencing of the card side by the select bit.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    localparam int LEN_W  = 10;
    localparam int CODE_W = 4;
    localparam int LEN_LSB  = 16;
    localparam int SEL_BIT  = 26;
    localparam int CODE_LSB = 28;

    typedef enum logic [1:0] {
        ADDR_LAUNCH = 2'd0,
        ADDR_WINDOW = 2'd1,
        ADDR_STATUS = 2'd2,
        ADDR_CTRL   = 2'd3
    } reg_addr_e;

    localparam int ST_EMPTY = 0;
    localparam int ST_UNR   = 1;
    localparam int ST_MIS   = 2;
    localparam int ST_DIR   = 3;
endpackage

// File: rtl/xfer_pktbuf_mem.sv
module xfer_pktbuf_mem #(
    parameter int DEPTH = 512,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic             we_wide,
    input  logic [PTR_W-1:0] wptr,
    input  logic [31:0]      wdata,
    input  logic [PTR_W-1:0] rptr,
    output logic [31:0]      rword
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int k = 0; k < 4; k++) begin
                if (we_wide || k == 0)
                    mem_q[wptr + PTR_W'(k)] <= wdata[31-8*k -: 8];
            end
        end
    end

    for (genvar k = 0; k < 4; k++) begin : g_lane
        assign rword[31-8*k -: 8] = mem_q[rptr + PTR_W'(k)];
    end
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
    import xfer_pkg::*;
#(
    parameter int BUF_BYTES = 512,
    localparam int PTR_W = $clog2(BUF_BYTES),
    localparam int LVL_W = $clog2(BUF_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_we,
    input  logic [31:0]       launch_word,
    input  logic              ctrl_we,
    input  logic              ctrl_dir,
    input  logic              win_wr,
    input  logic              win_rd,
    input  logic              clr_unr,
    input  logic              clr_mis,
    input  logic              rx_valid,
    input  logic              tx_ready,
    input  logic              card_end,
    output logic [CODE_W-1:0] code,
    output logic [LEN_W-1:0]  len,
    output logic              sel,
    output logic              dir,
    output logic [LVL_W-1:0]  level,
    output logic [LEN_W-1:0]  count,
    output logic              unr,
    output logic              mis,
    output logic [PTR_W-1:0]  wptr,
    output logic [PTR_W-1:0]  rptr,
    output logic              mem_we,
    output logic              mem_wide,
    output logic              tx_valid
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [LEN_W-1:0]  len;
        logic              sel;
        logic              dir;
        logic [LVL_W-1:0]  level;
        logic [PTR_W-1:0]  wptr;
        logic [PTR_W-1:0]  rptr;
        logic [LEN_W-1:0]  count;
        logic              unr;
        logic              mis;
    } state_t;

    state_t s_q, s_d;
    logic host_push, card_push, card_pop, empty_rd;
    logic [2:0] push_n, pop_n, host_pop_n;

    always_comb begin
        s_d        = s_q;
        host_push  = s_q.dir && win_wr && (s_q.level <= LVL_W'(BUF_BYTES - 4));
        card_push  = !s_q.dir && s_q.sel && rx_valid && (s_q.level < LVL_W'(BUF_BYTES));
        card_pop   = s_q.dir && s_q.sel && (s_q.level != '0) && tx_ready;
        empty_rd   = !s_q.dir && win_rd && (s_q.level == '0);
        host_pop_n = 3'd0;
        if (!s_q.dir && win_rd && s_q.level != '0)
            host_pop_n = (s_q.level >= LVL_W'(4)) ? 3'd4 : 3'(s_q.level);
        push_n = host_push ? 3'd4 : (card_push ? 3'd1 : 3'd0);
        pop_n  = card_pop ? 3'd1 : host_pop_n;

        s_d.level = s_q.level + LVL_W'(push_n) - LVL_W'(pop_n);
        s_d.wptr  = s_q.wptr + PTR_W'(push_n);
        s_d.rptr  = s_q.rptr + PTR_W'(pop_n);
        s_d.count = s_q.count + LEN_W'(push_n);

        if (launch_we) begin
            s_d.code  = launch_word[CODE_LSB +: CODE_W];
            s_d.len   = launch_word[LEN_LSB +: LEN_W];
            s_d.sel   = launch_word[SEL_BIT];
            s_d.count = '0;
        end
        if (ctrl_we)
            s_d.dir = ctrl_dir;

        if (clr_unr) s_d.unr = 1'b0;
        if (empty_rd) s_d.unr = 1'b1;
        if (clr_mis) s_d.mis = 1'b0;
        if (card_end && (s_d.count != s_d.len)) s_d.mis = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign code     = s_q.code;
    assign len      = s_q.len;
    assign sel      = s_q.sel;
    assign dir      = s_q.dir;
    assign level    = s_q.level;
    assign count    = s_q.count;
    assign unr      = s_q.unr;
    assign mis      = s_q.mis;
    assign wptr     = s_q.wptr;
    assign rptr     = s_q.rptr;
    assign mem_we   = host_push || card_push;
    assign mem_wide = host_push;
    assign tx_valid = s_q.dir && s_q.sel && (s_q.level != '0);

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.level <= LVL_W'(BUF_BYTES));                                          // R4
    AST_HOST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && s_q.dir && s_q.level > LVL_W'(BUF_BYTES - 4) && !launch_we)
        |=> s_q.count == $past(s_q.count));                                       // R4
    AST_RX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !s_q.dir && s_q.level == LVL_W'(BUF_BYTES) && !launch_we)
        |=> s_q.count == $past(s_q.count));                                       // R6
    AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (win_rd && !s_q.dir && s_q.level == '0) |=> s_q.unr);                     // R10
    AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.unr && !clr_unr) |=> s_q.unr);                                       // R10
    AST_MISMATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (card_end && !rx_valid && !win_wr && !launch_we && s_q.count != s_q.len)
        |=> s_q.mis);                                                             // R11
endmodule

// File: rtl/xfer_launch_buf.sv
module xfer_launch_buf
    import xfer_pkg::*;
#(
    parameter int BUF_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        card_tx_valid,
    output logic [7:0]  card_tx_data,
    input  logic        card_tx_ready,
    input  logic        card_rx_valid,
    input  logic [7:0]  card_rx_data,
    input  logic        card_end
);
    localparam int PTR_W = $clog2(BUF_BYTES);
    localparam int LVL_W = $clog2(BUF_BYTES + 1);

    logic [CODE_W-1:0] code;
    logic [LEN_W-1:0]  len, count;
    logic              sel, dir, unr, mis, mem_we, mem_wide;
    logic [LVL_W-1:0]  level;
    logic [PTR_W-1:0]  wptr, rptr;
    logic [31:0]       rword, win_data, mem_wdata;
    logic              wr_launch, wr_win, wr_status, wr_ctrl, rd_win;

    assign wr_launch = reg_wr && reg_addr == ADDR_LAUNCH;
    assign wr_win    = reg_wr && reg_addr == ADDR_WINDOW;
    assign wr_status = reg_wr && reg_addr == ADDR_STATUS;
    assign wr_ctrl   = reg_wr && reg_addr == ADDR_CTRL;
    assign rd_win    = reg_rd && reg_addr == ADDR_WINDOW;
    assign mem_wdata = mem_wide ? reg_wdata : {card_rx_data, 24'h0};

    xfer_ctrl #(.BUF_BYTES(BUF_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .launch_we(wr_launch), .launch_word(reg_wdata),
        .ctrl_we(wr_ctrl), .ctrl_dir(reg_wdata[0]),
        .win_wr(wr_win), .win_rd(rd_win),
        .clr_unr(wr_status && reg_wdata[ST_UNR]),
        .clr_mis(wr_status && reg_wdata[ST_MIS]),
        .rx_valid(card_rx_valid), .tx_ready(card_tx_ready), .card_end(card_end),
        .code(code), .len(len), .sel(sel), .dir(dir), .level(level),
        .count(count), .unr(unr), .mis(mis), .wptr(wptr), .rptr(rptr),
        .mem_we(mem_we), .mem_wide(mem_wide), .tx_valid(card_tx_valid)
    );

    xfer_pktbuf_mem #(.DEPTH(BUF_BYTES)) u_mem (
        .clk(clk), .we(mem_we), .we_wide(mem_wide), .wptr(wptr),
        .wdata(mem_wdata), .rptr(rptr), .rword(rword)
    );

    for (genvar k = 0; k < 4; k++) begin : g_win
        assign win_data[31-8*k -: 8] =
            (!dir && level > LVL_W'(k)) ? rword[31-8*k -: 8] : 8'h00;
    end

    assign card_tx_data = rword[31:24];

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_LAUNCH: begin
                reg_rdata[CODE_LSB +: CODE_W] = code;
                reg_rdata[SEL_BIT]            = sel;
                reg_rdata[LEN_LSB +: LEN_W]   = len;
            end
            ADDR_WINDOW: reg_rdata = win_data;
            ADDR_STATUS: begin
                reg_rdata[ST_EMPTY]         = (level == '0);
                reg_rdata[ST_UNR]           = unr;
                reg_rdata[ST_MIS]           = mis;
                reg_rdata[ST_DIR]           = dir;
                reg_rdata[4 +: LVL_W]       = level;
                reg_rdata[LEN_LSB +: LEN_W] = count;
            end
            default: reg_rdata[0] = dir;
        endcase
    end

    AST_TX_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        card_tx_valid |-> (reg_addr != ADDR_STATUS || !reg_rdata[ST_EMPTY]));   // R5
    AST_SEL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> !card_tx_valid);                                               // R7
endmodule

// File: tb/test_xfer_launch_buf.sv
module test_xfer_launch_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        card_tx_valid;
    logic [7:0]  card_tx_data;
    logic        card_tx_ready = 1'b0, card_rx_valid = 1'b0, card_end = 1'b0;
    logic [7:0]  card_rx_data = '0;
    int          n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    xfer_launch_buf i_xfer_launch_buf (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .card_tx_valid(card_tx_valid), .card_tx_data(card_tx_data),
        .card_tx_ready(card_tx_ready), .card_rx_valid(card_rx_valid),
        .card_rx_data(card_rx_data), .card_end(card_end)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] st(bit emp, bit unr, bit mis, bit dir, int lvl, int cnt);
        return (32'(cnt) << 16) | (32'(lvl) << 4) | {28'h0, dir, mis, unr, emp};
    endfunction

    task automatic bus_wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic bus_rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic chk_rd(string req, logic [1:0] a, logic [31:0] exp);
        logic [31:0] d;
        bus_rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic push_rx(logic [7:0] b, bit with_end);
        @(negedge clk); card_rx_valid = 1'b1; card_rx_data = b; card_end = with_end;
        @(negedge clk); card_rx_valid = 1'b0; card_end = 1'b0;
    endtask

    task automatic pop_tx(string req, logic [7:0] exp);
        @(negedge clk);
        chk(req, {31'h0, card_tx_valid}, 32'h1);
        chk(req, {24'h0, card_tx_data}, {24'h0, exp});
        card_tx_ready = 1'b1;
        @(negedge clk); card_tx_ready = 1'b0;
    endtask

    task automatic pulse_end();
        @(negedge clk); card_end = 1'b1;
        @(negedge clk); card_end = 1'b0;
    endtask

    function automatic logic [31:0] pat(int i);
        return {8'(i), ~8'(i), 8'h5A, 8'(i)};
    endfunction

    task automatic t_reset();
        chk_rd("R9 reset status", 2'd2, st(1, 0, 0, 0, 0, 0));
        chk_rd("R1 reset launch", 2'd0, 32'h0);
        chk("R5 reset tx_valid", {31'h0, card_tx_valid}, 32'h0);
    endtask

    task automatic t_launch_fields();
        bus_wr(2'd0, 32'hA408_00FF);
        chk_rd("R1 launch readback", 2'd0, 32'hA408_0000);
    endtask

    task automatic t_write_dir();
        bus_wr(2'd3, 32'h1);
        bus_wr(2'd1, 32'h1122_3344);
        bus_wr(2'd1, 32'h5566_7788);
        chk_rd("R3 count after host writes", 2'd2, st(0, 0, 0, 1, 8, 8));
        for (int i = 0; i < 8; i++) pop_tx("R2 R5 tx byte order", 8'(8'h11 * (i + 1)));
        @(negedge clk);
        chk("R5 tx idle when empty", {31'h0, card_tx_valid}, 32'h0);
        pulse_end();
        chk_rd("R11 exact length no mismatch", 2'd2, st(1, 0, 0, 1, 0, 8));
        chk_rd("R3 window read in write dir", 2'd1, 32'h0);
        chk_rd("R3 no underrun in write dir", 2'd2, st(1, 0, 0, 1, 0, 8));
    endtask

    task automatic t_host_full_drop();
        bus_wr(2'd0, 32'h0600_0000);
        for (int i = 0; i < 128; i++) bus_wr(2'd1, pat(i));
        bus_wr(2'd1, 32'hDEAD_BEEF);
        chk_rd("R4 full buffer drop", 2'd2, st(0, 0, 0, 1, 512, 512));
        pulse_end();
        chk_rd("R11 512 no mismatch", 2'd2, st(0, 0, 0, 1, 512, 512));
        for (int i = 0; i < 512; i++) begin
            logic [31:0] w = pat(i / 4);
            pop_tx("R4 drain content", w[31 - 8 * (i % 4) -: 8]);
        end
        @(negedge clk);
        chk("R4 dropped word absent", {31'h0, card_tx_valid}, 32'h0);
    endtask

    task automatic t_read_dir_ignore_write();
        bus_wr(2'd3, 32'h0);
        bus_wr(2'd1, 32'h1234_5678);
        chk_rd("R3 write ignored in read dir", 2'd2, st(1, 0, 0, 0, 0, 512));
    endtask

    task automatic t_read_dir();
        bus_wr(2'd0, 32'h3406_0000);
        for (int i = 0; i < 6; i++) push_rx(8'(8'hA1 + i), 1'b0);
        chk_rd("R6 rx count", 2'd2, st(0, 0, 0, 0, 6, 6));
        chk_rd("R2 R8 full word", 2'd1, 32'hA1A2_A3A4);
        chk_rd("R8 short word padded", 2'd1, 32'hA5A6_0000);
        pulse_end();
        chk_rd("R9 empty after drain", 2'd2, st(1, 0, 0, 0, 0, 6));
        chk_rd("R10 empty read data", 2'd1, 32'h0);
        chk_rd("R10 underrun set", 2'd2, st(1, 1, 0, 0, 0, 6));
        bus_wr(2'd2, 32'h2);
        chk_rd("R10 underrun cleared", 2'd2, st(1, 0, 0, 0, 0, 6));
    endtask

    task automatic t_mismatch();
        bus_wr(2'd0, 32'h3404_0000);
        for (int i = 0; i < 3; i++) push_rx(8'(8'hB1 + i), 1'b0);
        pulse_end();
        chk_rd("R11 short count mismatch", 2'd2, st(0, 0, 1, 0, 3, 3));
        bus_wr(2'd0, 32'h3404_0000);
        chk_rd("R1 relaunch keeps flag", 2'd2, st(0, 0, 1, 0, 3, 0));
        bus_wr(2'd2, 32'h4);
        chk_rd("R11 mismatch cleared", 2'd2, st(0, 0, 0, 0, 3, 0));
        chk_rd("R8 three bytes padded", 2'd1, 32'hB1B2_B300);
        for (int i = 0; i < 3; i++) push_rx(8'(8'hC1 + i), 1'b0);
        push_rx(8'hC4, 1'b1);
        chk_rd("R11 same-cycle byte counted", 2'd2, st(0, 0, 0, 0, 4, 4));
        chk_rd("R2 rx order", 2'd1, 32'hC1C2_C3C4);
    endtask

    task automatic t_select_off();
        bus_wr(2'd0, 32'h3004_0000);
        push_rx(8'h77, 1'b0);
        chk_rd("R7 rx dropped sel0", 2'd2, st(1, 0, 0, 0, 0, 0));
        bus_wr(2'd3, 32'h1);
        bus_wr(2'd1, 32'hCAFE_F00D);
        @(negedge clk);
        chk("R7 tx quiet sel0", {31'h0, card_tx_valid}, 32'h0);
        bus_wr(2'd0, 32'h3404_0000);
        pop_tx("R5 tx after sel1", 8'hCA);
        pop_tx("R5 tx after sel1", 8'hFE);
        pop_tx("R5 tx after sel1", 8'hF0);
        pop_tx("R5 tx after sel1", 8'h0D);
        chk_rd("R9 status write dir empty", 2'd2, st(1, 0, 0, 1, 0, 0));
    endtask

    task automatic t_rx_full();
        bus_wr(2'd3, 32'h0);
        bus_wr(2'd0, 32'h3600_0000);
        for (int i = 0; i < 513; i++) push_rx(8'(i), 1'b0);
        chk_rd("R6 rx full drop", 2'd2, st(0, 0, 0, 0, 512, 512));
        for (int i = 0; i < 128; i++) begin
            logic [31:0] d;
            bus_rd(2'd1, d);
            if (i == 0)   chk("R6 first word", d, 32'h0001_0203);
            if (i == 127) chk("R6 last word", d, 32'hFCFD_FEFF);
        end
        chk_rd("R9 empty after full drain", 2'd2, st(1, 0, 0, 0, 0, 512));
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL all: watchdog expired, actual running expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_launch_fields();
        t_write_dir();
        t_host_full_drop();
        t_read_dir_ignore_write();
        t_read_dir();
        t_mismatch();
        t_select_off();
        t_rx_full();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule